// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block sits beside the store queue of an out-of-order core and decides, for each load presented to it, whether the load may take its data straight from an older store still waiting in the queue. It looks at every queue entry and picks the youngest store that is older than the load and whose bytes overlap the load's bytes. From that one store it reaches one of three outcomes. The load may be forwarded the store's data. It may go to memory as a normal read. Or it is held back because the overlap cannot be served by forwarding.

A held load stays held while the store that caused it remains in the queue. Once that entry leaves, which means it has been written to the cache, the block releases the load and evaluates it again. The block counts every new hold event. It also reports whether any older store still has an unresolved address, so that a disambiguation predictor can decide whether the load should issue speculatively.

The requester keeps the load request asserted until it accepts an outcome. Each decision appears on the outputs one clock after the cycle in which the block evaluated the request.

Top module: `stlf_fwd_check`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs fwd_valid_o, blocked_o, mem_read_o and unknown_o are 0, fwd_data_o is 0, and blk_cnt_o is 0.
- R2: A store queue entry is a candidate only when it is valid, its address is resolved, it is older than the load, and it overlaps the load's bytes. An entry is older when it is committed or when its age is numerically smaller than the load's age. If several entries are candidates, the youngest one is used. Every uncommitted older entry is younger than every committed entry. Within the same group, a larger age is younger. Valid entries that are younger than the load are ignored.
- R3: If no entry is a candidate, the block raises mem_read_o for one cycle, one cycle after it evaluated the load, with fwd_valid_o and blocked_o low.
- R4: Forwarding happens when the chosen store contains every byte of the load and both the store and the load are naturally aligned to their own sizes. Size code k means 2^k bytes (0 = 1 B, 3 = 8 B). fwd_data_o is then the store data shifted right by 8 × (load address − store address) bits, with every byte at or above the load size cleared to zero.
- R5: If the chosen store overlaps the load only in part, including the case where the store is smaller than the load, the block raises blocked_o instead of forwarding.
- R6: If the chosen store contains the load but either of the two addresses is not aligned to its own size, the block raises blocked_o.
- R7: Once blocked_o is raised, it stays high while the blocking entry remains valid and ld_valid_i stays high. In the cycle after the block sees that entry's valid bit low, all outcome flags are low. If the load is still requested, the block evaluates it afresh in that cycle and the new outcome appears one cycle later.
- R8: blk_cnt_o increases by exactly one for each new blocking decision. It does not change while a load remains held. It wraps at 2^CNT_W.
- R9: unknown_o is reported alongside each fresh decision. It is 1 when any valid, older entry has an unresolved address. Entries with unresolved addresses are never candidates.
- R10: With ld_valid_i low, none of fwd_valid_o, mem_read_o or blocked_o is raised in the following cycle. At most one of the three is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load request present; held until accepted |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | 2 | Load size code (2^k bytes) |
| ld_age_i | input | AGE_W | Load age; smaller is older |
| sq_valid_i | input | SQ_N | Store entry valid |
| sq_known_i | input | SQ_N | Store address resolved |
| sq_committed_i | input | SQ_N | Store committed (older than any load) |
| sq_addr_i | input | SQ_N×ADDR_W | Store byte addresses |
| sq_size_i | input | SQ_N×2 | Store size codes |
| sq_age_i | input | SQ_N×AGE_W | Store ages |
| sq_data_i | input | SQ_N×DATA_W | Store data, byte 0 in the low bits |
| fwd_valid_o | output | 1 | Forwarded data is valid |
| fwd_data_o | output | DATA_W | Forwarded data, zero-extended |
| mem_read_o | output | 1 | Load proceeds as a normal memory read |
| blocked_o | output | 1 | Load is held by a partially overlapping store |
| unknown_o | output | 1 | An older store address is unresolved |
| blk_cnt_o | output | CNT_W | Count of blocking events |

## Verification
The assertions check several properties on every cycle. At most one outcome flag is high. An idle request produces no outcome. A held load remains held while its store entry stays valid, and it is released in the cycle after that entry leaves. The event counter only ever steps by one, and it steps on each rising edge of blocked_o. The bench scenarios cover what needs known data and addresses: the exact shifted and truncated forward values, the choice of the youngest store when several overlap, the difference between partial overlap, misalignment and clean containment, the fact that younger or unresolved stores are ignored, and the re-evaluation after release.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } hold_state_e;

  function automatic logic [7:0] size_bytes(input logic [SIZE_W-1:0] code);
    return 8'd1 << code;
  endfunction
endpackage

// File: rtl/sq_entry_cmp.sv
module sq_entry_cmp
  import stlf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 4,
  parameter int OFF_W  = 3
) (
  input  logic                valid_i,
  input  logic                known_i,
  input  logic                committed_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [AGE_W-1:0]    age_i,
  input  logic [ADDR_W-1:0]   ld_addr_i,
  input  logic [SIZE_W-1:0]   ld_size_i,
  input  logic [AGE_W-1:0]    ld_age_i,
  output logic                cand_o,
  output logic                unknown_o,
  output logic                fwd_ok_o,
  output logic [AGE_W:0]      key_o,
  output logic [OFF_W-1:0]    off_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic [7:0]       st_bytes, ld_bytes;
  logic [EXT_W-1:0] st_lo, st_hi, ld_lo, ld_hi;
  logic             older, overlap, contain, aligned;

  always_comb begin
    st_bytes = size_bytes(size_i);
    ld_bytes = size_bytes(ld_size_i);
    st_lo    = {1'b0, addr_i};
    ld_lo    = {1'b0, ld_addr_i};
    st_hi    = st_lo + {{(EXT_W-8){1'b0}}, st_bytes};
    ld_hi    = ld_lo + {{(EXT_W-8){1'b0}}, ld_bytes};
    older    = valid_i && (committed_i || (age_i < ld_age_i));
    overlap  = (ld_lo < st_hi) && (st_lo < ld_hi);
    contain  = (ld_lo >= st_lo) && (ld_hi <= st_hi);
    aligned  = ((addr_i[7:0] & (st_bytes - 8'd1)) == 8'd0) &&
               ((ld_addr_i[7:0] & (ld_bytes - 8'd1)) == 8'd0);
    cand_o    = older && known_i && overlap;
    unknown_o = older && !known_i;
    fwd_ok_o  = contain && aligned;
    // committed entries rank below every uncommitted older entry
    key_o     = {!committed_i, age_i};
    off_o     = ld_addr_i[OFF_W-1:0] - addr_i[OFF_W-1:0];
  end
endmodule

// File: rtl/sq_youngest_sel.sv
module sq_youngest_sel #(
  parameter int N     = 8,
  parameter int KEY_W = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][KEY_W-1:0] key_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [KEY_W-1:0] best;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!hit_o || key_i[i] > best)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = key_i[i];
      end
    end
  end
endmodule

// File: rtl/fwd_data_align.sv
module fwd_data_align
  import stlf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 3
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] shifted;
  logic [7:0]        nb;

  always_comb begin
    shifted = data_i >> {off_i, 3'b000};
    nb      = size_bytes(size_i);
    data_o  = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (8'(b) < nb) data_o[b*8 +: 8] = shifted[b*8 +: 8];
    end
  end
endmodule

// File: rtl/stlf_evt_counter.sv
module stlf_evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 1'b1)); // R8
endmodule

// File: rtl/stlf_fwd_check.sv
module stlf_fwd_check
  import stlf_pkg::*;
#(
  parameter int SQ_N   = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int AGE_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ld_valid_i,
  input  logic [ADDR_W-1:0]             ld_addr_i,
  input  logic [1:0]                    ld_size_i,
  input  logic [AGE_W-1:0]              ld_age_i,
  input  logic [SQ_N-1:0]               sq_valid_i,
  input  logic [SQ_N-1:0]               sq_known_i,
  input  logic [SQ_N-1:0]               sq_committed_i,
  input  logic [SQ_N-1:0][ADDR_W-1:0]   sq_addr_i,
  input  logic [SQ_N-1:0][1:0]          sq_size_i,
  input  logic [SQ_N-1:0][AGE_W-1:0]    sq_age_i,
  input  logic [SQ_N-1:0][DATA_W-1:0]   sq_data_i,
  output logic                          fwd_valid_o,
  output logic [DATA_W-1:0]             fwd_data_o,
  output logic                          mem_read_o,
  output logic                          blocked_o,
  output logic                          unknown_o,
  output logic [CNT_W-1:0]              blk_cnt_o
);
  localparam int IDX_W = (SQ_N > 1) ? $clog2(SQ_N) : 1;
  localparam int KEY_W = AGE_W + 1;
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic [SQ_N-1:0]             cand, unk, fwd_ok;
  logic [SQ_N-1:0][KEY_W-1:0]  key;
  logic [SQ_N-1:0][OFF_W-1:0]  off;

  for (genvar g = 0; g < SQ_N; g++) begin : g_ent
    sq_entry_cmp #(.ADDR_W(ADDR_W), .AGE_W(AGE_W), .OFF_W(OFF_W)) u_cmp (
      .valid_i     (sq_valid_i[g]),
      .known_i     (sq_known_i[g]),
      .committed_i (sq_committed_i[g]),
      .addr_i      (sq_addr_i[g]),
      .size_i      (sq_size_i[g]),
      .age_i       (sq_age_i[g]),
      .ld_addr_i   (ld_addr_i),
      .ld_size_i   (ld_size_i),
      .ld_age_i    (ld_age_i),
      .cand_o      (cand[g]),
      .unknown_o   (unk[g]),
      .fwd_ok_o    (fwd_ok[g]),
      .key_o       (key[g]),
      .off_o       (off[g])
    );
  end

  logic             hit;
  logic [IDX_W-1:0] sel_idx;

  sq_youngest_sel #(.N(SQ_N), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_sel (
    .cand_i (cand),
    .key_i  (key),
    .hit_o  (hit),
    .idx_o  (sel_idx)
  );

  logic [DATA_W-1:0] aligned_data;

  fwd_data_align #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_align (
    .data_i (sq_data_i[sel_idx]),
    .off_i  (off[sel_idx]),
    .size_i (ld_size_i),
    .data_o (aligned_data)
  );

  logic dec_fwd, dec_blk, dec_mem, dec_unk;
  hold_state_e      state_q;
  logic [IDX_W-1:0] hold_idx_q;
  logic             blk_evt;

  always_comb begin
    dec_fwd = ld_valid_i && hit && fwd_ok[sel_idx];
    dec_blk = ld_valid_i && hit && !fwd_ok[sel_idx];
    dec_mem = ld_valid_i && !hit;
    dec_unk = ld_valid_i && (|unk);
    blk_evt = (state_q == ST_IDLE) && dec_blk;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      hold_idx_q  <= '0;
      fwd_valid_o <= 1'b0;
      fwd_data_o  <= '0;
      mem_read_o  <= 1'b0;
      blocked_o   <= 1'b0;
      unknown_o   <= 1'b0;
    end else if (state_q == ST_HOLD) begin
      fwd_valid_o <= 1'b0;
      fwd_data_o  <= '0;
      mem_read_o  <= 1'b0;
      unknown_o   <= 1'b0;
      if (!ld_valid_i || !sq_valid_i[hold_idx_q]) begin
        state_q   <= ST_IDLE;
        blocked_o <= 1'b0;
      end else begin
        blocked_o <= 1'b1;
      end
    end else begin
      fwd_valid_o <= dec_fwd;
      fwd_data_o  <= dec_fwd ? aligned_data : '0;
      mem_read_o  <= dec_mem;
      blocked_o   <= dec_blk;
      unknown_o   <= dec_unk;
      if (dec_blk) begin
        state_q    <= ST_HOLD;
        hold_idx_q <= sel_idx;
      end
    end
  end

  stlf_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (blk_evt),
    .cnt_o  (blk_cnt_o)
  );

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd_valid_o, mem_read_o, blocked_o})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> !(fwd_valid_o || mem_read_o || blocked_o)); // R10
  AST_HOLD_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && ld_valid_i && sq_valid_i[hold_idx_q]) |=> blocked_o); // R7
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !sq_valid_i[hold_idx_q]) |=> !blocked_o); // R7
  AST_CNT_ON_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blocked_o) |-> (blk_cnt_o != $past(blk_cnt_o))); // R8
endmodule

// File: tb/stlf_fwd_check_bench.sv
`timescale 1ns/1ps
module stlf_fwd_check_bench;
  localparam int N = 8, AW = 32, DW = 64, GW = 4, CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                  ld_valid;
  logic [AW-1:0]         ld_addr;
  logic [1:0]            ld_size;
  logic [GW-1:0]         ld_age;
  logic [N-1:0]          sq_valid, sq_known, sq_comm;
  logic [N-1:0][AW-1:0]  sq_addr;
  logic [N-1:0][1:0]     sq_size;
  logic [N-1:0][GW-1:0]  sq_age;
  logic [N-1:0][DW-1:0]  sq_data;
  logic                  fwd_v, mem_rd, blk, unk;
  logic [DW-1:0]         fwd_d;
  logic [CW-1:0]         cnt;

  stlf_fwd_check u_stlf_fwd_check (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_size_i(ld_size), .ld_age_i(ld_age),
    .sq_valid_i(sq_valid), .sq_known_i(sq_known), .sq_committed_i(sq_comm),
    .sq_addr_i(sq_addr), .sq_size_i(sq_size), .sq_age_i(sq_age), .sq_data_i(sq_data),
    .fwd_valid_o(fwd_v), .fwd_data_o(fwd_d), .mem_read_o(mem_rd),
    .blocked_o(blk), .unknown_o(unk), .blk_cnt_o(cnt)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_sq();
    sq_valid = '0; sq_known = '0; sq_comm = '0;
    sq_addr = '0; sq_size = '0; sq_age = '0; sq_data = '0;
  endtask

  task automatic put(input int i, input logic [AW-1:0] a, input logic [1:0] s,
                     input logic [DW-1:0] d, input logic [GW-1:0] g,
                     input logic c, input logic k);
    sq_valid[i] = 1'b1; sq_known[i] = k; sq_comm[i] = c;
    sq_addr[i] = a; sq_size[i] = s; sq_data[i] = d; sq_age[i] = g;
  endtask

  // drive at negedge, decision registers at next posedge, sample at following negedge
  task automatic load(input logic [AW-1:0] a, input logic [1:0] s, input logic [GW-1:0] g);
    ld_valid = 1'b1; ld_addr = a; ld_size = s; ld_age = g;
    @(negedge clk);
  endtask

  task automatic idle();
    ld_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 fwd", 64'(fwd_v), 64'd0);
    chk("R1 mem", 64'(mem_rd), 64'd0);
    chk("R1 blk", 64'(blk), 64'd0);
    chk("R1 unk", 64'(unk), 64'd0);
    chk("R1 data", fwd_d, 64'd0);
    chk("R1 cnt", 64'(cnt), 64'd0);
  endtask

  task automatic t_no_overlap();
    clear_sq();
    put(0, 32'h80, 2'd3, 64'hAAAA, 4'd1, 1'b0, 1'b1);
    load(32'h100, 2'd3, 4'd5);
    chk("R3 mem", 64'(mem_rd), 64'd1);
    chk("R3 fwd", 64'(fwd_v), 64'd0);
    idle();
    chk("R10 idle", 64'({fwd_v, mem_rd, blk}), 64'd0);
  endtask

  task automatic t_forward();
    clear_sq();
    put(2, 32'h100, 2'd3, 64'h1122334455667788, 4'd2, 1'b0, 1'b1);
    load(32'h104, 2'd2, 4'd6);
    chk("R4 fwd 4B", 64'(fwd_v), 64'd1);
    chk("R4 data 4B", fwd_d, 64'h11223344);
    load(32'h103, 2'd0, 4'd6);
    chk("R4 data 1B", fwd_d, 64'h55);
    load(32'h102, 2'd1, 4'd6);
    chk("R4 data 2B", fwd_d, 64'h5566);
    load(32'h100, 2'd3, 4'd6);
    chk("R4 data 8B", fwd_d, 64'h1122334455667788);
    idle();
  endtask

  task automatic t_youngest();
    clear_sq();
    put(0, 32'h200, 2'd3, 64'hA0, 4'd1, 1'b0, 1'b1);
    put(1, 32'h200, 2'd3, 64'hB0, 4'd3, 1'b0, 1'b1);
    put(2, 32'h200, 2'd3, 64'hC0, 4'd12, 1'b1, 1'b1);
    put(3, 32'h200, 2'd3, 64'hD0, 4'd9, 1'b0, 1'b1); // younger than load
    load(32'h200, 2'd3, 4'd5);
    chk("R2 youngest", fwd_d, 64'hB0);
    sq_valid[1] = 1'b0;
    load(32'h200, 2'd3, 4'd5);
    chk("R2 uncommitted over committed", fwd_d, 64'hA0);
    sq_valid[0] = 1'b0;
    load(32'h200, 2'd3, 4'd5);
    chk("R2 committed", fwd_d, 64'hC0);
    sq_valid[2] = 1'b0;
    load(32'h200, 2'd3, 4'd5);
    chk("R2 younger ignored", 64'(mem_rd), 64'd1);
    idle();
  endtask

  task automatic t_partial();
    clear_sq();
    put(4, 32'h300, 2'd3, 64'h1, 4'd1, 1'b0, 1'b1);
    load(32'h306, 2'd2, 4'd4);
    chk("R5 blocked", 64'(blk), 64'd1);
    chk("R8 cnt 1", 64'(cnt), 64'd1);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R7 held", 64'(blk), 64'd1);
    chk("R8 no recount", 64'(cnt), 64'd1);
    sq_valid[4] = 1'b0;
    @(negedge clk);
    chk("R7 released", 64'({fwd_v, mem_rd, blk}), 64'd0);
    @(negedge clk);
    chk("R7 reeval", 64'(mem_rd), 64'd1);
    idle();
  endtask

  task automatic t_smaller_store();
    clear_sq();
    put(5, 32'h400, 2'd2, 64'h1, 4'd1, 1'b0, 1'b1);
    load(32'h400, 2'd3, 4'd4);
    chk("R5 small store", 64'(blk), 64'd1);
    chk("R8 cnt 2", 64'(cnt), 64'd2);
    idle();
    chk("R7 drop", 64'(blk), 64'd0);
  endtask

  task automatic t_misaligned();
    clear_sq();
    put(6, 32'h502, 2'd2, 64'h1, 4'd1, 1'b0, 1'b1);
    load(32'h502, 2'd1, 4'd4);
    chk("R6 misaligned", 64'(blk), 64'd1);
    chk("R6 no fwd", 64'(fwd_v), 64'd0);
    chk("R8 cnt 3", 64'(cnt), 64'd3);
    idle();
  endtask

  task automatic t_unknown();
    clear_sq();
    put(7, 32'h600, 2'd3, 64'h1, 4'd2, 1'b0, 1'b0);
    load(32'h600, 2'd3, 4'd4);
    chk("R9 unknown", 64'(unk), 64'd1);
    chk("R9 not candidate", 64'(mem_rd), 64'd1);
    sq_age[7] = 4'd9;
    load(32'h600, 2'd3, 4'd4);
    chk("R9 younger unknown", 64'(unk), 64'd0);
    idle();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ld_valid = 1'b0; ld_addr = '0; ld_size = '0; ld_age = '0;
    clear_sq();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_overlap();
    t_forward();
    t_youngest();
    t_partial();
    t_smaller_store();
    t_misaligned();
    t_unknown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule